// File: doc/BRIEF.md
# Byte-Stream Command Packet Bridge

This block sits between a UART's byte FIFOs and a simple memory-mapped register bus. It reads a stream of received bytes and frames them into fixed 12-byte request packets. Each packet starts with the marker 0xDE and has a second marker, 0xCA, at byte 7. The bridge decodes each accepted packet as one single-word read or write on the bus. It then returns a 12-byte response through the transmit FIFO.

The 32-bit request address is taken big-endian from bytes 2 to 5. Its upper four bits select a peripheral and its lower 28 bits give the location within that peripheral. Bytes 8 to 11 carry a 32-bit data word, most significant byte first. The response echoes the header bytes and returns the word that was written or read. When a bus transfer never completes, or the command is unknown, the response marks the failure in the command byte.

Top module: `pkt_bridge`

## Requirements
- R1: After a synchronous active-high reset, rxReady is 1, while txValid, busRd, busWr and pktErr are 0.
- R2: While hunting for a packet, any received byte other than 0xDE is discarded. pktErr is high for exactly one cycle for each discarded byte, and no response is produced.
- R3: If byte 7 of a packet is not 0xCA, the packet is dropped. pktErr pulses once, no bus strobe is raised, no response is sent, and the bridge hunts again for 0xDE starting with the next byte.
- R4: Command byte 0x02 (byte 1) produces a write. busWr is raised with busPeriph equal to bits 31:28 and busMemAddr equal to bits 27:0 of the big-endian address in bytes 2 to 5. busWrData equals bytes 8 to 11, with byte 8 most significant. The strobe and these values are held until busDone is sampled high.
- R5: Command byte 0x01 produces a read. busRd is held until busDone is sampled high, and busRdData is captured in that same cycle.
- R6: Every accepted packet yields exactly 12 response bytes. Bytes 0 to 7 echo the request; byte 6, the length field, is echoed but never checked. Bytes 8 to 11 carry a data word, most significant byte first: the written word for a write, the captured word for a read.
- R7: If busDone does not arrive, the strobe stays high for exactly 256 cycles and is then dropped. The response command byte then has bit 7 set, and the data bytes echo the request data.
- R8: A command byte other than 0x01 or 0x02 raises no bus strobe. Its response has bit 7 of the command byte set and echoes the request data.
- R9: rxReady is low from the last byte of an accepted packet until the final response byte is taken. txData holds steady while txValid is high and txReady is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxData | input | 8 | Byte from the receive FIFO |
| rxValid | input | 1 | Receive byte available |
| rxReady | output | 1 | Bridge takes the receive byte |
| txData | output | 8 | Response byte to the transmit FIFO |
| txValid | output | 1 | Response byte available |
| txReady | input | 1 | Transmit FIFO takes the byte |
| busPeriph | output | 4 | Peripheral select (address bits 31:28) |
| busMemAddr | output | 28 | Location inside the peripheral |
| busWrData | output | 32 | Write data word |
| busRdData | input | 32 | Read data word |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| busDone | input | 1 | Bus transfer complete |
| pktErr | output | 1 | One-cycle pulse on a discarded byte or dropped packet |

## Verification
The hardest situation to reach is a bus transfer that is abandoned. The bridge must hold the strobe for the full 256 cycles, drop it, and still send a well-formed response with the failure mark, all without leaving state that corrupts the next packet. The bench gets there with a bench-side peripheral that can be told to withhold busDone, for both a write and a read. It then follows with a normal read of the same location to show that the abandoned write stored nothing. The dropped-frame case is reached by corrupting byte 7 and letting the packet's tail bytes be re-hunted as junk.

// File: rtl/pkt_bridge_pkg.sv
package pkt_bridge_pkg;
  localparam int PKT_LEN    = 12;
  localparam int HDR_LEN    = 8;
  localparam int DATA_BYTES = PKT_LEN - HDR_LEN;
  localparam int DATA_W     = 8 * DATA_BYTES;
  localparam int ADDR_W     = 32;
  localparam int PERIPH_W   = 4;
  localparam int MEM_W      = ADDR_W - PERIPH_W;
  localparam int IDX_W      = $clog2(PKT_LEN);

  localparam logic [7:0] START_MARK = 8'hDE;
  localparam logic [7:0] SYNC_MARK  = 8'hCA;
  localparam logic [7:0] CMD_RD     = 8'h01;
  localparam logic [7:0] CMD_WR     = 8'h02;
  localparam int         SYNC_POS   = 7;

  typedef enum logic [1:0] {ST_HUNT, ST_COLLECT, ST_BUS, ST_SEND} stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic             hdrLoad;
    logic             dataShift;
    logic             rdCapture;
    logic             failMark;
    logic [IDX_W-1:0] byteIdx;
  } dpCtlT;
endpackage

// File: rtl/pkt_bridge_dp.sv
module pkt_bridge_dp
  import pkt_bridge_pkg::*;
(
  input  logic              clk,
  input  dpCtlT             ctl,
  input  logic [7:0]        rxData,
  input  logic [DATA_W-1:0] busRdData,
  output logic [7:0]        cmdByte,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  output logic [7:0]        txData
);
  logic [7:0]        hdr [HDR_LEN];
  logic [DATA_W-1:0] dataWord;
  logic [7:0]        dataLane [DATA_BYTES];

  always_ff @(posedge clk) begin
    if (ctl.hdrLoad) hdr[ctl.byteIdx[2:0]] <= rxData;
    if (ctl.dataShift)      dataWord <= {dataWord[DATA_W-9:0], rxData};
    else if (ctl.rdCapture) dataWord <= busRdData;
  end

  // data lanes, most significant byte first
  for (genvar g = 0; g < DATA_BYTES; g++) begin : gLane
    assign dataLane[g] = dataWord[DATA_W-1-8*g -: 8];
  end

  assign cmdByte   = hdr[1];
  assign busAddr   = {hdr[2], hdr[3], hdr[4], hdr[5]};
  assign busWrData = dataWord;

  always_comb begin
    if (ctl.byteIdx < IDX_W'(HDR_LEN)) begin
      txData = hdr[ctl.byteIdx[2:0]];
      if (ctl.byteIdx == IDX_W'(1) && ctl.failMark) txData[7] = 1'b1;
    end else begin
      txData = dataLane[ctl.byteIdx[1:0]];
    end
  end
endmodule

// File: rtl/pkt_bridge_ctl.sv
module pkt_bridge_ctl
  import pkt_bridge_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 256
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       txReady,
  input  logic       busDone,
  input  logic [7:0] cmdByte,
  output logic       rxReady,
  output logic       txValid,
  output logic       busRd,
  output logic       busWr,
  output logic       pktErr,
  output dpCtlT      ctl
);
  localparam int TMO_W = $clog2(TIMEOUT_CYCLES);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_LEN - 1);

  stateT            state;
  logic [IDX_W-1:0] byteCnt;
  logic [TMO_W-1:0] tmoCnt;
  logic             fail;
  logic             errReg;
  logic             rxFire, txFire, isRd, isWr;

  assign isRd    = (cmdByte == CMD_RD);
  assign isWr    = (cmdByte == CMD_WR);
  assign rxReady = (state == ST_HUNT) || (state == ST_COLLECT);
  assign txValid = (state == ST_SEND);
  assign rxFire  = rxValid && rxReady;
  assign txFire  = txValid && txReady;
  assign busWr   = (state == ST_BUS) && isWr;
  assign busRd   = (state == ST_BUS) && isRd;
  assign pktErr  = errReg;

  always_comb begin
    ctl.byteIdx   = byteCnt;
    ctl.failMark  = fail;
    ctl.hdrLoad   = rxFire && ((state == ST_HUNT) ? (rxData == START_MARK)
                                                  : (byteCnt < IDX_W'(HDR_LEN)));
    ctl.dataShift = rxFire && (state == ST_COLLECT) && (byteCnt >= IDX_W'(HDR_LEN));
    ctl.rdCapture = busRd && busDone;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      byteCnt <= '0;
      tmoCnt  <= '0;
      fail    <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      errReg <= 1'b0;
      unique case (state)
        ST_HUNT: if (rxFire) begin
          if (rxData == START_MARK) begin
            byteCnt <= IDX_W'(1);
            state   <= ST_COLLECT;
          end else begin
            errReg <= 1'b1;
          end
        end
        ST_COLLECT: if (rxFire) begin
          if (byteCnt == IDX_W'(SYNC_POS) && rxData != SYNC_MARK) begin
            errReg  <= 1'b1;
            byteCnt <= '0;
            state   <= ST_HUNT;
          end else if (byteCnt == IDX_LAST) begin
            byteCnt <= '0;
            tmoCnt  <= '0;
            if (isRd || isWr) begin
              fail  <= 1'b0;
              state <= ST_BUS;
            end else begin
              fail  <= 1'b1;
              state <= ST_SEND;
            end
          end else begin
            byteCnt <= byteCnt + 1'b1;
          end
        end
        ST_BUS: begin
          if (busDone) begin
            state <= ST_SEND;
          end else if (tmoCnt == TMO_LAST) begin
            fail  <= 1'b1;
            state <= ST_SEND;
          end else begin
            tmoCnt <= tmoCnt + 1'b1;
          end
        end
        ST_SEND: if (txFire) begin
          if (byteCnt == IDX_LAST) begin
            byteCnt <= '0;
            state   <= ST_HUNT;
          end else begin
            byteCnt <= byteCnt + 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  // R4: write strobe stays up until done or the last timeout cycle
  a_r4_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (busWr && !busDone && tmoCnt != TMO_LAST) |=> busWr);
  // R5: read strobe stays up the same way
  a_r5_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (busRd && !busDone && tmoCnt != TMO_LAST) |=> busRd);
  // R7: an expired transfer leads straight into a marked response
  a_r7_timeout_mark: assert property (@(posedge clk) disable iff (rst)
    ((busRd || busWr) && !busDone && tmoCnt == TMO_LAST) |=> (txValid && fail && !busRd && !busWr));
  // R9: no byte is taken while the response is going out
  a_r9_rx_closed: assert property (@(posedge clk) disable iff (rst)
    txValid |-> !rxReady);
endmodule

// File: rtl/pkt_bridge.sv
module pkt_bridge
  import pkt_bridge_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 256
)(
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          rxData,
  input  logic                rxValid,
  output logic                rxReady,
  output logic [7:0]          txData,
  output logic                txValid,
  input  logic                txReady,
  output logic [PERIPH_W-1:0] busPeriph,
  output logic [MEM_W-1:0]    busMemAddr,
  output logic [DATA_W-1:0]   busWrData,
  input  logic [DATA_W-1:0]   busRdData,
  output logic                busRd,
  output logic                busWr,
  input  logic                busDone,
  output logic                pktErr
);
  dpCtlT             ctl;
  logic [7:0]        cmdByte;
  logic [ADDR_W-1:0] busAddr;

  pkt_bridge_ctl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) ctl_i (
    .clk(clk), .rst(rst), .rxValid(rxValid), .rxData(rxData),
    .txReady(txReady), .busDone(busDone), .cmdByte(cmdByte),
    .rxReady(rxReady), .txValid(txValid), .busRd(busRd), .busWr(busWr),
    .pktErr(pktErr), .ctl(ctl)
  );

  pkt_bridge_dp dp_i (
    .clk(clk), .ctl(ctl), .rxData(rxData), .busRdData(busRdData),
    .cmdByte(cmdByte), .busAddr(busAddr), .busWrData(busWrData), .txData(txData)
  );

  assign busPeriph  = busAddr[ADDR_W-1 -: PERIPH_W];
  assign busMemAddr = busAddr[MEM_W-1:0];

  // R9: a stalled response byte does not change
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txReady) |=> (txValid && $stable(txData)));
  // R4: address and data stay put while a write waits
  a_r4_bus_stable: assert property (@(posedge clk) disable iff (rst)
    (busWr && !busDone) |=> (!busWr || ($stable(busPeriph) && $stable(busMemAddr) && $stable(busWrData))));
  // R3: a rejection never coincides with a bus strobe
  a_r3_err_no_strobe: assert property (@(posedge clk) disable iff (rst)
    pktErr |-> !(busRd || busWr));
  // R2: after a rejection the bridge is back hunting
  a_r2_err_hunting: assert property (@(posedge clk) disable iff (rst)
    pktErr |-> (rxReady && !txValid));
endmodule

// File: tb/pkt_bridge_tb_top.sv
module pkt_bridge_tb_top;
  typedef logic [7:0] pktT [12];

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        rxReady;
  logic [7:0]  txData;
  logic        txValid;
  logic        txReady;
  logic [3:0]  busPeriph;
  logic [27:0] busMemAddr;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic        busRd, busWr, busDone;
  logic        pktErr;

  always #4 clk = ~clk;

  pkt_bridge dut_i (
    .clk(clk), .rst(rst), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .busPeriph(busPeriph), .busMemAddr(busMemAddr), .busWrData(busWrData),
    .busRdData(busRdData), .busRd(busRd), .busWr(busWr), .busDone(busDone),
    .pktErr(pktErr)
  );

  int vecCnt = 0, missCnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (!ok) begin
      missCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
  endtask

  // bench-side peripheral
  logic [31:0] periMem [16];
  logic [31:0] expMem  [16];
  int doneDelay = 0;
  bit hangBus = 0;
  int waitCnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      busDone <= 1'b0;
      waitCnt <= 0;
    end else begin
      busDone <= 1'b0;
      if ((busRd || busWr) && !busDone && !hangBus) begin
        if (waitCnt >= doneDelay) begin
          busDone   <= 1'b1;
          waitCnt   <= 0;
          busRdData <= periMem[busMemAddr[3:0]];
          if (busWr) periMem[busMemAddr[3:0]] <= busWrData;
        end else begin
          waitCnt <= waitCnt + 1;
        end
      end
    end
  end

  // transmit side: drive txReady and collect accepted bytes
  logic [7:0] rspQ [$];
  bit   txStall = 0;
  logic prevTxValid = 0, prevTxReady = 0;
  logic [7:0] prevTxData = 0;
  int   holdBad = 0, overlapBad = 0;

  always @(negedge clk) begin
    if (prevTxValid && !prevTxReady && txValid && txData != prevTxData) holdBad++;
    if (txValid && rxReady) overlapBad++;
    txReady = txStall ? (($urandom % 3) != 0) : 1'b1;
    if (txValid && txReady) rspQ.push_back(txData);
    prevTxValid = txValid;
    prevTxReady = txReady;
    prevTxData  = txData;
  end

  // bus and error monitor
  int errCnt = 0, strobeEvents = 0, runLen = 0, lastRun = 0, bothBad = 0;
  logic [31:0] addrSeen, dataSeen;
  bit wrSeen;

  always @(negedge clk) begin
    if (!rst) begin
      if (pktErr) errCnt++;
      if (busRd && busWr) bothBad++;
      if (busRd || busWr) begin
        if (runLen == 0) begin
          addrSeen = {busPeriph, busMemAddr};
          dataSeen = busWrData;
          wrSeen   = busWr;
        end
        runLen++;
      end else if (runLen > 0) begin
        lastRun = runLen;
        strobeEvents++;
        runLen = 0;
      end
    end
  end

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxData  = b;
    rxValid = 1'b1;
    while (!rxReady) @(negedge clk);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  function automatic pktT makePkt(input logic [7:0] cmd, input logic [31:0] addr,
                                  input logic [7:0] len, input logic [31:0] data);
    pktT p;
    p[0] = 8'hDE; p[1] = cmd;
    p[2] = addr[31:24]; p[3] = addr[23:16]; p[4] = addr[15:8]; p[5] = addr[7:0];
    p[6] = len; p[7] = 8'hCA;
    p[8] = data[31:24]; p[9] = data[23:16]; p[10] = data[15:8]; p[11] = data[7:0];
    return p;
  endfunction

  // send one good packet, predict bus activity and response, compare
  task automatic runPkt(input pktT p, input int dly, input string req);
    logic [31:0] reqAddr, reqData, retData;
    logic [3:0]  idx;
    bit isRd, isWr, fail;
    pktT exp;
    int evBefore;
    reqAddr = {p[2], p[3], p[4], p[5]};
    reqData = {p[8], p[9], p[10], p[11]};
    idx  = p[5][3:0];
    isRd = (p[1] == 8'h01);
    isWr = (p[1] == 8'h02);
    fail = hangBus || !(isRd || isWr);
    retData = (isRd && !fail) ? expMem[idx] : reqData;
    if (isWr && !fail) expMem[idx] = reqData;
    for (int i = 0; i < 8; i++) exp[i] = p[i];
    if (fail) exp[1] = p[1] | 8'h80;
    for (int i = 0; i < 4; i++) exp[8+i] = retData[31-8*i -: 8];

    rspQ.delete();
    holdBad = 0; overlapBad = 0;
    evBefore = strobeEvents;
    doneDelay = dly;
    for (int i = 0; i < 12; i++) sendByte(p[i]);
    for (int w = 0; w < 3000 && rspQ.size() < 12; w++) @(negedge clk);
    repeat (4) @(negedge clk);

    check(rspQ.size() == 12, "R6", {req, " response length"}, rspQ.size(), 12);
    for (int i = 0; i < 12; i++)
      if (i < rspQ.size())
        check(rspQ[i] == exp[i], (i == 1 && fail) ? "R7/R8" : "R6",
              $sformatf("%s response byte %0d", req, i), rspQ[i], exp[i]);
    if (isRd || isWr) begin
      check(strobeEvents == evBefore + 1, isWr ? "R4" : "R5", {req, " strobe count"},
            strobeEvents - evBefore, 1);
      check(addrSeen == reqAddr, "R4", {req, " bus address"}, addrSeen, reqAddr);
      check(wrSeen == isWr, isWr ? "R4" : "R5", {req, " strobe kind"}, wrSeen, isWr);
      if (isWr) check(dataSeen == reqData, "R4", {req, " write data"}, dataSeen, reqData);
      check(lastRun == (hangBus ? 256 : dly + 2), hangBus ? "R7" : "R4",
            {req, " strobe length"}, lastRun, hangBus ? 256 : dly + 2);
    end else begin
      check(strobeEvents == evBefore, "R8", {req, " no strobe"}, strobeEvents - evBefore, 0);
    end
    check(holdBad == 0 && overlapBad == 0, "R9", {req, " tx hold / rx closed"},
          holdBad + overlapBad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    missCnt++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    int e0, s0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      periMem[i] = {4{8'(i * 17 + 3)}};
      expMem[i]  = periMem[i];
    end
    busRdData = '0;
    rxValid = 1'b0;
    rxData  = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rxReady == 1'b1, "R1", "rxReady after reset", rxReady, 1);
    check({txValid, busRd, busWr, pktErr} == 4'b0, "R1", "outputs idle after reset",
          {txValid, busRd, busWr, pktErr}, 0);

    // directed: 0xFF to 0x20, then read back
    runPkt(makePkt(8'h02, 32'h0000_0020, 8'h04, 32'h0000_00FF), 0, "R4 write 0x20");
    runPkt(makePkt(8'h01, 32'h0000_0020, 8'h04, 32'h0), 1, "R5 read 0x20");

    // R2: junk while hunting
    e0 = errCnt; s0 = strobeEvents; rspQ.delete();
    sendByte(8'h00); sendByte(8'hCA); sendByte(8'hDF);
    repeat (3) @(negedge clk);
    check(errCnt - e0 == 3, "R2", "error pulses for junk", errCnt - e0, 3);
    check(rspQ.size() == 0 && strobeEvents == s0, "R2", "junk makes no activity",
          rspQ.size(), 0);

    // R3: bad second marker, tail re-hunted as junk
    e0 = errCnt; s0 = strobeEvents; rspQ.delete();
    begin
      pktT bad;
      bad = makePkt(8'h02, 32'h0000_0003, 8'h04, 32'h1111_1111);
      bad[7] = 8'h55;
      for (int i = 0; i < 12; i++) sendByte(bad[i]);
    end
    repeat (300) @(negedge clk);
    check(errCnt - e0 == 5, "R3", "error pulses for bad frame", errCnt - e0, 5);
    check(strobeEvents == s0, "R3", "no strobe for bad frame", strobeEvents - s0, 0);
    check(rspQ.size() == 0, "R3", "no response for bad frame", rspQ.size(), 0);
    runPkt(makePkt(8'h01, 32'h0000_0003, 8'h04, 32'h0), 0, "R3 recovery read");

    // R7: timeouts on write and read, then prove nothing stored
    hangBus = 1;
    runPkt(makePkt(8'h02, 32'h3000_0005, 8'h04, 32'h1234_5678), 0, "R7 write timeout");
    runPkt(makePkt(8'h01, 32'h3000_0006, 8'h04, 32'h0BAD_F00D), 0, "R7 read timeout");
    hangBus = 0;
    runPkt(makePkt(8'h01, 32'h3000_0005, 8'h04, 32'h0), 2, "R7 after-timeout read");

    // R8: unknown commands
    runPkt(makePkt(8'h05, 32'h0000_0001, 8'h04, 32'hCAFE_0001), 0, "R8 cmd 05");
    runPkt(makePkt(8'h00, 32'h0000_0002, 8'h04, 32'hDEAD_BEEF), 0, "R8 cmd 00");

    // random mix with a stalling transmit FIFO
    txStall = 1;
    for (int n = 0; n < 40; n++) begin
      logic [7:0] cmd;
      cmd = (($urandom % 2) == 0) ? 8'h02 : 8'h01;
      runPkt(makePkt(cmd, $urandom, 8'($urandom), $urandom), int'($urandom % 6),
             cmd == 8'h02 ? "R4 random write" : "R5 random read");
    end
    txStall = 0;
    check(bothBad == 0, "R4", "read and write never together", bothBad, 0);

    report();
    $finish;
  end
endmodule